// File: doc/BRIEF.md
# Paged Byte Register File with Working-Register Windows

This block is a 256-location byte register file for a small controller core. The file is split into sixteen groups of sixteen bytes. Two address translations sit in front of the storage. First, the top group (0xF0-0xFF) is a window onto one of several peripheral register pages, and a page pointer held in the system group selects which page appears there. Second, short 4-bit working-register operands r0-r15 are relocated onto any aligned block of the file by two pointer registers, also held in the system group.

The file has two combinational read ports and one synchronous write port. Each port carries a flag that says whether its address is a full 8-bit direct address or a 4-bit working-register index. Group D (0xD0-0xDF) has no direct meaning. A direct address in that range is treated as a working-register index taken from its low nibble. The pointer and page registers are ordinary locations in the file, so software changes the mapping by writing them. A new mapping is used from the cycle after the write.

Top module: `pgreg_file`

## Requirements
- R1: After reset every location reads 0x00 on both read ports. This includes the pointer registers, so every page and window starts at 0.
- R2: A direct address (flag low) outside 0xD0-0xDF and outside 0xF0-0xFF reaches that exact location. A write there is read back unchanged from the next cycle onward.
- R3: With the page pointer (location 0xEA) at a value P below the number of physical pages (4), direct address 0xF0+n reaches byte n of page P. Bytes at the same offset on different pages are independent storage.
- R4: With the page pointer at 4 or above, every access that lands in 0xF0-0xFF reads 0x00, and writes there change no page.
- R5: When bit 0 of location 0xE9 is 0 (single-window mode), working index n maps to address {E8[7:4], n}. Bit 3 of the pointer base is treated as zero.
- R6: When bit 0 of location 0xE9 is 1 (dual-window mode), index n from 0 to 7 maps to {E8[7:3], n[2:0]}. Index n from 8 to 15 maps to {E9[7:3], n[2:0]}.
- R7: A direct address in 0xD0-0xDF behaves exactly like working index addr[3:0] and is translated through the active window(s).
- R8: A read and a write that reach the same location in the same cycle return the data held before the write. The new data is visible on the following cycle.
- R9: A write to 0xE8, 0xE9 or 0xEA does not alter translations in the cycle of the write. It alters them from the next cycle on.
- R10: The two read ports translate and read independently. Each may use its own addressing form in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rda_wreg | input | 1 | Read port A: 1 = working-register index in rda_addr[3:0] |
| rda_addr | input | 8 | Read port A address |
| rda_data | output | 8 | Read port A data (combinational) |
| rdb_wreg | input | 1 | Read port B: 1 = working-register index |
| rdb_addr | input | 8 | Read port B address |
| rdb_data | output | 8 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_wreg | input | 1 | Write port: 1 = working-register index |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |

## Verification
The bench targets five areas. It checks that bit 3 is cleared from the base in single-window mode; a design that kept it would shift every odd-aligned window by eight bytes. It checks the r7/r8 split between the two pointers in dual-window mode. It checks the empty pages at pointer values 4 and 5, where a design that wrapped the pointer would alias page 0 or 1 and corrupt it on writes. It checks that 0xD0-0xDF goes through the windows rather than to raw storage. Finally, it checks the same-cycle cases: a read beside a write to the same location, and a pointer write beside a windowed read. A design that bypassed write data or pointers would show new values one cycle early.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;
  localparam int DW        = 8;
  localparam int AW        = 8;
  localparam int GRP_SZ    = 16;
  localparam logic [3:0] PAGE_GRP = 4'hF;
  localparam logic [3:0] WIN_GRP  = 4'hD;
  localparam logic [7:0] PTR0_LOC = 8'hE8;
  localparam logic [7:0] PTR1_LOC = 8'hE9;
  localparam logic [7:0] PAGE_LOC = 8'hEA;
  localparam int DUAL_BIT  = 0;

  // does this operand go through the working-register windows
  function automatic logic uses_window(input logic wreg, input logic [AW-1:0] a);
    return wreg || (a[7:4] == WIN_GRP);
  endfunction

  // working index -> physical address
  function automatic logic [AW-1:0] window_map(input logic [DW-1:0] p0,
                                               input logic [DW-1:0] p1,
                                               input logic dual,
                                               input logic [3:0] idx);
    if (!dual)       return {p0[7:4], idx};
    else if (!idx[3]) return {p0[7:3], idx[2:0]};
    else             return {p1[7:3], idx[2:0]};
  endfunction
endpackage

// File: rtl/pgreg_xlate.sv
module pgreg_xlate
  import pgreg_pkg::*;
(
  input  logic          wreg,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] ptr0,
  input  logic [DW-1:0] ptr1,
  output logic [AW-1:0] phys,
  output logic          windowed
);
  assign windowed = uses_window(wreg, addr);
  assign phys     = windowed ? window_map(ptr0, ptr1, ptr1[DUAL_BIT], addr[3:0]) : addr;
endmodule

// File: rtl/pgreg_store.sv
module pgreg_store
  import pgreg_pkg::*;
#(
  parameter int NPAGES = 4,
  parameter int NRD    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_phys,
  input  logic [DW-1:0]           wr_data,
  input  logic [NRD-1:0][AW-1:0]  rd_phys,
  output logic [NRD-1:0][DW-1:0]  rd_data,
  output logic [DW-1:0]           ptr0,
  output logic [DW-1:0]           ptr1,
  output logic [DW-1:0]           page_sel,
  output logic                    page_ok,
  output logic                    wr_commit
);
  localparam int MAIN_N = int'(PAGE_GRP) * GRP_SZ;
  localparam int PG_N   = NPAGES * GRP_SZ;
  localparam int PIDX_W = $clog2(PG_N);

  logic [DW-1:0] main_q [MAIN_N];
  logic [DW-1:0] page_q [PG_N];

  assign ptr0     = main_q[PTR0_LOC];
  assign ptr1     = main_q[PTR1_LOC];
  assign page_sel = main_q[PAGE_LOC];
  assign page_ok  = int'(page_sel) < NPAGES;

  function automatic logic [PIDX_W-1:0] page_idx(input logic [3:0] lo);
    return PIDX_W'(int'(page_sel) * GRP_SZ + int'(lo));
  endfunction

  function automatic logic [DW-1:0] fetch(input logic [AW-1:0] pa);
    if (pa[7:4] == PAGE_GRP) return page_ok ? page_q[page_idx(pa[3:0])] : '0;
    else                     return main_q[pa];
  endfunction

  logic wr_to_page;
  assign wr_to_page = (wr_phys[7:4] == PAGE_GRP);
  assign wr_commit  = wr_en && (!wr_to_page || page_ok);

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = fetch(rd_phys[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAIN_N; i++) main_q[i] <= '0;
    end else if (wr_commit && !wr_to_page) begin
      main_q[wr_phys] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PG_N; i++) page_q[i] <= '0;
    end else if (wr_commit && wr_to_page) begin
      page_q[page_idx(wr_phys[3:0])] <= wr_data;
    end
  end
endmodule

// File: rtl/pgreg_file.sv
module pgreg_file
  import pgreg_pkg::*;
#(
  parameter int NPAGES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rda_wreg,
  input  logic [AW-1:0] rda_addr,
  output logic [DW-1:0] rda_data,
  input  logic          rdb_wreg,
  input  logic [AW-1:0] rdb_addr,
  output logic [DW-1:0] rdb_data,
  input  logic          wr_en,
  input  logic          wr_wreg,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam int NRD   = 2;
  localparam int NPORT = NRD + 1;
  localparam int WRP   = NRD;

  logic [NPORT-1:0]          p_wreg;
  logic [NPORT-1:0][AW-1:0]  p_addr;
  logic [NPORT-1:0][AW-1:0]  p_phys;
  logic [NPORT-1:0]          p_win;
  logic [NRD-1:0][DW-1:0]    rd_data;

  logic [DW-1:0] ptr0, ptr1, page_sel;
  logic          page_ok, wr_commit;
  // named events for the checker
  logic [AW-1:0] a_phys, w_phys;

  assign p_wreg = {wr_wreg, rdb_wreg, rda_wreg};
  assign p_addr = {wr_addr, rdb_addr, rda_addr};

  for (genvar g = 0; g < NPORT; g++) begin : g_xl
    pgreg_xlate u_xl (
      .wreg     (p_wreg[g]),
      .addr     (p_addr[g]),
      .ptr0     (ptr0),
      .ptr1     (ptr1),
      .phys     (p_phys[g]),
      .windowed (p_win[g])
    );
  end

  assign a_phys = p_phys[0];
  assign w_phys = p_phys[WRP];

  pgreg_store #(.NPAGES(NPAGES), .NRD(NRD)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_phys   (p_phys[WRP]),
    .wr_data   (wr_data),
    .rd_phys   (p_phys[NRD-1:0]),
    .rd_data   (rd_data),
    .ptr0      (ptr0),
    .ptr1      (ptr1),
    .page_sel  (page_sel),
    .page_ok   (page_ok),
    .wr_commit (wr_commit)
  );

  assign rda_data = rd_data[0];
  assign rdb_data = rd_data[1];
endmodule

// File: rtl/pgreg_checker.sv
module pgreg_checker #(
  parameter int NPAGES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_wreg,
  input logic [7:0] rd_addr,
  input logic [7:0] rd_data,
  input logic [7:0] rd_phys,
  input logic       wr_commit,
  input logic [7:0] wr_phys,
  input logic [7:0] wr_data,
  input logic [7:0] ptr0,
  input logic [7:0] ptr1,
  input logic [7:0] page_sel
);
  logic win;
  assign win = rd_wreg || (rd_addr[7:4] == 4'hD);

  assert_direct_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !win |-> rd_phys == rd_addr);

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (rd_phys != $past(wr_phys)) || !$stable(page_sel) || (rd_data == $past(wr_data)));

  assert_empty_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phys[7:4] == 4'hF) && (int'(page_sel) >= NPAGES) |-> rd_data == 8'h00);

  assert_single_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win && !ptr1[0] |-> (rd_phys[7:4] == ptr0[7:4]) && (rd_phys[3:0] == rd_addr[3:0]));

  assert_dual_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win && ptr1[0] |-> (rd_phys[2:0] == rd_addr[2:0]) &&
                       (rd_phys[7:3] == (rd_addr[3] ? ptr1[7:3] : ptr0[7:3])));

  assert_pointer_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit && (wr_phys == 8'hE8) |=> ptr0 == $past(wr_data));
endmodule

bind pgreg_file pgreg_checker #(.NPAGES(NPAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_wreg   (rda_wreg),
  .rd_addr   (rda_addr),
  .rd_data   (rda_data),
  .rd_phys   (a_phys),
  .wr_commit (wr_commit),
  .wr_phys   (w_phys),
  .wr_data   (wr_data),
  .ptr0      (ptr0),
  .ptr1      (ptr1),
  .page_sel  (page_sel)
);

// File: tb/pgreg_file_tb.sv
`timescale 1ns/1ps
module pgreg_file_tb_top;
  localparam int NPG = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rda_wreg = 1'b0, rdb_wreg = 1'b0, wr_en = 1'b0, wr_wreg = 1'b0;
  logic [7:0] rda_addr = '0, rdb_addr = '0, wr_addr = '0, wr_data = '0;
  logic [7:0] rda_data, rdb_data;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference state
  int rf [256];
  int pg [NPG][16];

  always #4 clk = ~clk;

  pgreg_file dut_i (
    .clk(clk), .rst_n(rst_n),
    .rda_wreg(rda_wreg), .rda_addr(rda_addr), .rda_data(rda_data),
    .rdb_wreg(rdb_wreg), .rdb_addr(rdb_addr), .rdb_data(rdb_data),
    .wr_en(wr_en), .wr_wreg(wr_wreg), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic int locate(bit w, int a);
    int n;
    if (!w && (a / 16) != 13) return a;
    n = a % 16;
    if (rf[233] % 2 == 0) return (rf[232] / 16) * 16 + n;
    if (n < 8)            return (rf[232] / 8) * 8 + n;
    return (rf[233] / 8) * 8 + (n - 8);
  endfunction

  function automatic int peek(int p);
    if (p < 240) return rf[p];
    if (rf[234] < NPG) return pg[rf[234]][p - 240];
    return 0;
  endfunction

  task automatic poke(int p, int d);
    if (p < 240) rf[p] = d;
    else if (rf[234] < NPG) pg[rf[234]][p - 240] = d;
  endtask

  task automatic compare(string tag, string port, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s port %s: got %02h expected %02h at %0t", tag, port, got, exp, $time);
    end
  endtask

  task automatic step(string tag, bit aw, int aa, bit bw, int ba,
                      bit we, bit ww, int wa, int wd);
    int wp;
    @(negedge clk);
    rda_wreg = aw; rda_addr = 8'(aa);
    rdb_wreg = bw; rdb_addr = 8'(ba);
    wr_en = we; wr_wreg = ww; wr_addr = 8'(wa); wr_data = 8'(wd);
    #1;
    compare(tag, "A", int'(rda_data), peek(locate(aw, aa)));
    compare(tag, "B", int'(rdb_data), peek(locate(bw, ba)));
    wp = locate(ww, wa);
    @(posedge clk);
    if (we) poke(wp, wd);
  endtask

  task automatic wr(string tag, bit w, int a, int d);
    step(tag, 1'b0, 8'h00, 1'b0, 8'hEA, 1'b1, w, a, d);
  endtask

  task automatic rd(string tag, bit aw, int aa, bit bw, int ba);
    step(tag, aw, aa, bw, ba, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) rf[i] = 0;
    for (int p = 0; p < NPG; p++) for (int i = 0; i < 16; i++) pg[p][i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: everything zero after reset
    rd("R1", 1'b0, 8'h00, 1'b0, 8'hEA);
    rd("R1", 1'b0, 8'hF5, 1'b0, 8'hD3);
    rd("R1", 1'b1, 8'h0F, 1'b0, 8'hE9);

    // R2: plain direct locations
    wr("R2", 1'b0, 8'h10, 8'h5A);
    wr("R2", 1'b0, 8'hC7, 8'h33);
    wr("R2", 1'b0, 8'hE1, 8'h77);
    rd("R2", 1'b0, 8'h10, 1'b0, 8'hC7);
    rd("R2", 1'b0, 8'hE1, 1'b0, 8'h11);

    // R8: same-cycle read of the written location gives old data
    step("R8", 1'b0, 8'h20, 1'b0, 8'h20, 1'b1, 1'b0, 8'h20, 8'h99);
    step("R8", 1'b0, 8'h20, 1'b0, 8'h20, 1'b1, 1'b0, 8'h20, 8'h42);
    rd("R8", 1'b0, 8'h20, 1'b0, 8'h10);

    // R3: paged group
    wr("R3", 1'b0, 8'hEA, 8'd2);
    wr("R3", 1'b0, 8'hF2, 8'hA5);
    wr("R3", 1'b0, 8'hEA, 8'd1);
    rd("R3", 1'b0, 8'hF2, 1'b0, 8'hEA);
    wr("R3", 1'b0, 8'hF2, 8'h3C);
    wr("R3", 1'b0, 8'hEA, 8'd2);
    rd("R3", 1'b0, 8'hF2, 1'b0, 8'hF3);
    wr("R3", 1'b0, 8'hEA, 8'd3);
    wr("R3", 1'b0, 8'hFF, 8'h11);
    rd("R3", 1'b0, 8'hFF, 1'b0, 8'hF2);

    // R4: pointer beyond physical pages
    wr("R4", 1'b0, 8'hEA, 8'd5);
    wr("R4", 1'b0, 8'hF2, 8'hEE);
    rd("R4", 1'b0, 8'hF2, 1'b0, 8'hFF);
    wr("R4", 1'b0, 8'hEA, 8'd4);
    wr("R4", 1'b0, 8'hF0, 8'hEF);
    rd("R4", 1'b0, 8'hF0, 1'b0, 8'hF2);
    for (int p = 0; p < NPG; p++) begin
      wr("R4", 1'b0, 8'hEA, p);
      rd("R4", 1'b0, 8'hF2, 1'b0, 8'hF0);
    end

    // R9: pointer write not used until next cycle
    wr("R9", 1'b0, 8'h43, 8'h6D);
    step("R9", 1'b1, 8'h03, 1'b1, 8'h03, 1'b1, 1'b0, 8'hE8, 8'h40);
    rd("R9", 1'b1, 8'h03, 1'b0, 8'h03);

    // R5: single window, bit 3 of base dropped
    wr("R5", 1'b0, 8'hE8, 8'h38);
    wr("R5", 1'b1, 8'h05, 8'h61);
    rd("R5", 1'b0, 8'h35, 1'b1, 8'h05);
    rd("R5", 1'b1, 8'h0D, 1'b0, 8'h3D);

    // R6: dual window
    wr("R6", 1'b0, 8'hE9, 8'h59);
    wr("R6", 1'b0, 8'hE8, 8'h20);
    wr("R6", 1'b1, 8'h02, 8'h12);
    wr("R6", 1'b1, 8'h0A, 8'h34);
    rd("R6", 1'b0, 8'h22, 1'b0, 8'h5A);
    rd("R6", 1'b1, 8'h07, 1'b1, 8'h08);

    // R7: direct group D goes through the windows
    rd("R7", 1'b0, 8'hD2, 1'b0, 8'hDA);
    wr("R7", 1'b0, 8'hD9, 8'h5E);
    rd("R7", 1'b0, 8'h59, 1'b0, 8'hD9);

    // R10: random mix on both ports
    for (int i = 0; i < 3000; i++) begin
      int wa, wd;
      wa = int'($urandom_range(0, 255));
      wd = int'($urandom_range(0, 255));
      if (wa == 8'hEA) wd = int'($urandom_range(0, 5));
      if (i % 7 == 0) begin wa = 8'hEA; wd = int'($urandom_range(0, 5)); end
      step("R10", 1'($urandom), int'($urandom_range(0, 255)),
                  1'($urandom), int'($urandom_range(0, 255)),
                  1'($urandom), 1'($urandom), wa, wd);
    end

    finish_run();
  end
endmodule